// File: doc/BRIEF.md
# Sticky Level-Event Capture Bank

This block watches eight input pins for an active level and records each occurrence in a per-channel status bit that stays set until software clears it. Because power-related and very short events may come and go while the bus clock is gated, each status bit is set asynchronously, straight from the pin. The clock is only needed to clear the bit and to read it. The active level of each pin is selectable. A per-channel view select can also show the live, non-sticky level instead of the stored one.

Software uses a small 32-bit register bus to program channel enables, polarity and view select. It reads the raw and masked status and clears bits with write-one-to-clear. The stored status passes through a two-flop synchronizer before it reaches the readback and the interrupt logic. The interrupt output is registered and is high whenever any enabled channel shows status.

Top module: `lvl_latch_bank`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The enable (0x00), polarity (0x10) and view (0x14) registers read back what was written in bits [7:0], with the upper bits reading zero. The clear register (0x0C) and every unmapped offset read as zero.
- R3: Polarity bit n = 0 makes a high level on pin n active, and 1 makes a low level active. An active level sets raw status bit n, which can be read at offset 0x04.
- R4: With view bit n = 0, raw status bit n stays set after pin n returns to its inactive level.
- R5: Writing 1 to bit n of the clear register (0x0C) clears the stored status of channel n. Bits written as 0 leave their channels untouched.
- R6: A clear has no effect on a channel whose active level is still present. Its status reads set afterwards.
- R7: Masked status (0x08) equals raw status AND enable. `irq_o` is high exactly when the masked status is nonzero.
- R8: A pulse shorter than one clock period is captured, including a pulse that arrives while the clock is stopped.
- R9: With view bit n = 1, raw status bit n follows the synchronized live active level instead of the stored bit. The stored bit keeps accumulating and reappears when view bit n returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and readback clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| evt_pin | input | 8 | Event inputs, one per channel |
| irq_o | output | 1 | Interrupt, OR of masked status |

## Verification
The assertions assume that pin levels are inactive while reset is asserted. They also assume that pins never change in the same time step as a rising clock edge, so a level that is active at an edge has already set its status flop. The stimulus drives pins and polarity only around falling edges or while the clock is stopped. It holds all pins at their inactive value during reset. Readback waits five clock cycles after any pin or register change, which covers the synchronizer and the registered interrupt.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    localparam int unsigned LBK_AW = 8;

    localparam logic [LBK_AW-1:0] OFF_ENA = 8'h00;
    localparam logic [LBK_AW-1:0] OFF_RAW = 8'h04;
    localparam logic [LBK_AW-1:0] OFF_MSK = 8'h08;
    localparam logic [LBK_AW-1:0] OFF_CLR = 8'h0C;
    localparam logic [LBK_AW-1:0] OFF_POL = 8'h10;
    localparam logic [LBK_AW-1:0] OFF_VIEW = 8'h14;
endpackage

// File: rtl/lbk_sync.sv
module lbk_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/lbk_cell.sv
module lbk_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic act_o,
    output logic cap_o
);
    logic act_w;
    logic cap_q;

    // polarity 0: high is active; polarity 1: low is active
    assign act_w = pin_i ^ pol_i;

    // set needs no clock; clear is synchronous and loses to an active level
    always_ff @(posedge clk or negedge rst_n or posedge act_w) begin
        if (!rst_n)
            cap_q <= 1'b0;
        else if (act_w)
            cap_q <= 1'b1;
        else if (clr_i)
            cap_q <= 1'b0;
    end

    assign act_o = act_w;
    assign cap_o = cap_q;
endmodule

// File: rtl/lbk_regs.sv
module lbk_regs
    import lbk_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 8,
    parameter int unsigned DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_en,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] cap_sync_i,
    input  logic [NCH-1:0] live_sync_i,
    output logic [NCH-1:0] ena_o,
    output logic [NCH-1:0] pol_o,
    output logic [NCH-1:0] clr_o,
    output logic [NCH-1:0] stat_o,
    output logic           irq_o
);
    typedef struct packed {
        logic [NCH-1:0] ena;
        logic [NCH-1:0] pol;
        logic [NCH-1:0] view;
        logic [NCH-1:0] clr;
        logic           irq;
    } regs_t;

    regs_t          st_d, st_q;
    logic [NCH-1:0] stat_w;
    logic           wr_w;

    assign wr_w = bus_en && bus_we;

    always_comb begin
        st_d     = st_q;
        st_d.clr = '0;
        stat_w   = (st_q.view & live_sync_i) | (~st_q.view & cap_sync_i);
        if (wr_w) begin
            case (bus_addr)
                AW'(OFF_ENA):  st_d.ena  = bus_wdata[NCH-1:0];
                AW'(OFF_CLR):  st_d.clr  = bus_wdata[NCH-1:0];
                AW'(OFF_POL):  st_d.pol  = bus_wdata[NCH-1:0];
                AW'(OFF_VIEW): st_d.view = bus_wdata[NCH-1:0];
                default: ;
            endcase
        end
        st_d.irq = |(stat_w & st_q.ena);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFF_ENA):  bus_rdata[NCH-1:0] = st_q.ena;
            AW'(OFF_RAW):  bus_rdata[NCH-1:0] = stat_w;
            AW'(OFF_MSK):  bus_rdata[NCH-1:0] = stat_w & st_q.ena;
            AW'(OFF_POL):  bus_rdata[NCH-1:0] = st_q.pol;
            AW'(OFF_VIEW): bus_rdata[NCH-1:0] = st_q.view;
            default: ;
        endcase
    end

    assign ena_o  = st_q.ena;
    assign pol_o  = st_q.pol;
    assign clr_o  = st_q.clr;
    assign stat_o = stat_w;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/lvl_latch_bank.sv
module lvl_latch_bank
    import lbk_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = LBK_AW,
    parameter int unsigned DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_en,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] evt_pin,
    output logic           irq_o
);
    localparam int unsigned FIT_OK = (NCH <= DW) ? 1 : 0;

    logic [NCH-1:0] act_w, cap_w, cap_s_w, live_s_w;
    logic [NCH-1:0] ena_w, pol_w, clr_w, stat_w;

    generate
        if (FIT_OK == 0) begin : g_bad_width
            initial $error("channel count exceeds data width");
        end
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            lbk_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .pin_i (evt_pin[i]),
                .pol_i (pol_w[i]),
                .clr_i (clr_w[i]),
                .act_o (act_w[i]),
                .cap_o (cap_w[i])
            );
        end
    endgenerate

    lbk_sync #(.W(NCH)) u_sync_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cap_w),
        .q_o   (cap_s_w)
    );

    lbk_sync #(.W(NCH)) u_sync_live (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (act_w),
        .q_o   (live_s_w)
    );

    lbk_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cap_sync_i  (cap_s_w),
        .live_sync_i (live_s_w),
        .ena_o       (ena_w),
        .pol_o       (pol_w),
        .clr_o       (clr_w),
        .stat_o      (stat_w),
        .irq_o       (irq_o)
    );
endmodule

// File: rtl/lbk_chk.sv
module lbk_chk
    import lbk_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 8,
    parameter int unsigned DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_en,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_rdata,
    input logic [NCH-1:0] act,
    input logic [NCH-1:0] cap,
    input logic [NCH-1:0] clr,
    input logic [NCH-1:0] stat,
    input logic [NCH-1:0] ena,
    input logic           irq
);
    // an active level seen at an edge has already set the stored bit
    p_active_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((act & ~cap) == '0));

    // a stored bit without a clear pulse survives the edge
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(cap) & ~$past(clr)) & ~cap) == '0));

    // the clear pulse lasts only the cycle after a clear write
    p_clr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && bus_addr == AW'(OFF_CLR)) |=> (clr == '0));

    // the clear offset reads zero
    p_clr_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == AW'(OFF_CLR)) |-> (bus_rdata == '0));

    // interrupt follows masked status one cycle later
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat & ena))));
endmodule

bind lvl_latch_bank lbk_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .act       (act_w),
    .cap       (cap_w),
    .clr       (clr_w),
    .stat      (stat_w),
    .ena       (ena_w),
    .irq       (irq_o)
);

// File: tb/sim_lvl_latch_bank.sv
`timescale 1ns/1ps
module sim_lvl_latch_bank;
    localparam logic [7:0] A_ENA = 8'h00, A_RAW = 8'h04, A_MSK = 8'h08;
    localparam logic [7:0] A_CLR = 8'h0C, A_POL = 8'h10, A_VIEW = 8'h14;

    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pins = '0;
    logic        irq;
    int          checks = 0, fails = 0;
    logic [31:0] rv;

    lvl_latch_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pin(pins), .irq_o(irq)
    );

    initial forever begin
        #10;
        if (clk_run) clk = ~clk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #4000000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] vals [3];
        logic [7:0] pats [3];
        vals[0] = 8'hFF; vals[1] = 8'h5A; vals[2] = 8'h00;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h5A;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 6; a++) begin
            rd(8'(a * 4), rv);
            chk("R1 reg", rv, 32'h0);
        end

        // R2: readback and zero reads
        for (int k = 0; k < 3; k++) begin
            wr(A_ENA, {24'hA5A5A5, vals[k]} | 32'hFF00_0000);
            wr(A_POL, {24'h3C3C3C, vals[k]});
            wr(A_VIEW, {24'hFFFFFF, vals[k]});
            rd(A_ENA, rv);  chk("R2 ena", rv, {24'h0, vals[k]});
            rd(A_POL, rv);  chk("R2 pol", rv, {24'h0, vals[k]});
            rd(A_VIEW, rv); chk("R2 view", rv, {24'h0, vals[k]});
        end
        rd(A_CLR, rv);  chk("R2 clr", rv, 32'h0);
        rd(8'h18, rv);  chk("R2 unmapped", rv, 32'h0);
        rd(8'h40, rv);  chk("R2 unmapped", rv, 32'h0);
        rd(8'hFC, rv);  chk("R2 unmapped", rv, 32'h0);

        // R3 R4 R5 R7: per-channel sweep under three polarity patterns
        for (int p = 0; p < 3; p++) begin
            logic [7:0] pp;
            pp = pats[p];
            @(negedge clk);
            pins = pp;
            wr(A_POL, {24'h0, pp});
            wr(A_CLR, 32'hFF);
            settle();
            rd(A_RAW, rv); chk("R5 clear all", rv, 32'h0);
            for (int ch = 0; ch < 8; ch++) begin
                logic [7:0] bit_m, en_m;
                bit_m = 8'h1 << ch;
                en_m = (ch % 2 == 1) ? 8'hFF : ~bit_m;
                wr(A_ENA, {24'h0, en_m});
                @(negedge clk);
                pins = pp ^ bit_m;
                repeat (2) @(negedge clk);
                pins = pp;
                settle();
                rd(A_RAW, rv); chk("R3 R4 raw capture", rv, {24'h0, bit_m});
                rd(A_MSK, rv); chk("R7 masked", rv, {24'h0, bit_m & en_m});
                chk("R7 irq", {31'b0, irq}, {31'b0, (bit_m & en_m) != 0});
                wr(A_CLR, {24'h0, bit_m});
                settle();
                rd(A_RAW, rv); chk("R5 clear one", rv, 32'h0);
                chk("R7 irq low", {31'b0, irq}, 32'h0);
            end
        end
        wr(A_POL, 32'h0);
        @(negedge clk); pins = 8'h00;
        wr(A_CLR, 32'hFF);
        wr(A_ENA, 32'hFF);

        // R5: clearing one bit leaves another
        @(negedge clk); pins = 8'h42;
        @(negedge clk); pins = 8'h00;
        settle();
        wr(A_CLR, 32'h02);
        settle();
        rd(A_RAW, rv); chk("R5 partial clear", rv, 32'h40);
        wr(A_CLR, 32'h40);
        settle();

        // R6: clear while the active level persists
        @(negedge clk); pins = 8'h04;
        settle();
        wr(A_CLR, 32'hFF);
        settle();
        rd(A_RAW, rv); chk("R6 clear blocked", rv, 32'h04);
        @(negedge clk); pins = 8'h00;
        settle();
        rd(A_RAW, rv); chk("R4 sticky after release", rv, 32'h04);
        wr(A_CLR, 32'h04);
        settle();
        rd(A_RAW, rv); chk("R6 clear after release", rv, 32'h0);

        // R8: short pulse while the clock is stopped
        @(negedge clk);
        clk_run = 1'b0;
        #40 pins = 8'h80;
        #3  pins = 8'h00;
        #40 clk_run = 1'b1;
        settle();
        rd(A_RAW, rv); chk("R8 stopped clock capture", rv, 32'h80);
        chk("R8 irq", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h80);
        settle();
        // R8: short pulse with the clock running
        @(negedge clk);
        #3 pins = 8'h08;
        #4 pins = 8'h00;
        settle();
        rd(A_RAW, rv); chk("R8 short pulse", rv, 32'h08);
        wr(A_CLR, 32'h08);
        settle();

        // R9: live view versus stored view
        wr(A_VIEW, 32'h0F);
        @(negedge clk); pins = 8'h11;
        settle();
        rd(A_RAW, rv); chk("R9 live and stored set", rv, 32'h11);
        @(negedge clk); pins = 8'h00;
        settle();
        rd(A_RAW, rv); chk("R9 live follows pin", rv, 32'h10);
        wr(A_VIEW, 32'h00);
        settle();
        rd(A_RAW, rv); chk("R9 stored bit reappears", rv, 32'h11);
        wr(A_CLR, 32'hFF);
        settle();
        rd(A_RAW, rv); chk("R9 cleared", rv, 32'h0);
        chk("R7 irq idle", {31'b0, irq}, 32'h0);

        finish_run();
    end
endmodule